// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a small multi-ported register store of the kind that feeds the operand stage of a processor datapath. It holds 32 words of 32 bits. One write port and two independent read ports are offered each clock cycle. Every port names its target word by a 5-bit index.

The write index is decoded into a one-hot enable vector, gated by a write-enable pin. The write value is presented to every word, and only the enabled word loads it on the rising clock edge. Each read port has its own decoder. That decoder produces a one-hot select, and the selected word is gathered onto the port's result bus as an AND-OR of all words. The gathered value is captured into a port output register on the falling clock edge. A word written at the rising edge of a cycle can therefore be read back at the falling edge of the same cycle.

All ports are plain control and data pins with no valid/ready handshake. The file accepts one write and two reads in every cycle, so it never applies back-pressure and has no stall condition. Callers must hold the indices, the write value and the write enable steady for the whole cycle, from one falling edge to the next. A synchronous active-high reset, sampled on both edges, clears all words and both read output registers.

Top module: `regfile_2r1w`

## Requirements
- R1: When `wr_en` is 1 at a rising edge, the word at index `wr_sel` takes `wr_data`, and all 31 other words keep their contents.
- R2: When `wr_en` is 0 at a rising edge, no word changes, whatever `wr_sel` and `wr_data` hold.
- R3: `rd_a_data` and `rd_b_data` each return the word named by their own index (`rd_a_sel`, `rd_b_sel`), independently of each other.
- R4: When both read indices name the same word, both read outputs carry identical data.
- R5: The read outputs change only at falling clock edges, and hold their value across a rising edge.
- R6: A read at the falling edge of a cycle returns the value written at the rising edge of that same cycle.
- R7: `rst` = 1 at a rising edge clears all 32 words to zero, even if `wr_en` is 1 in that cycle. `rst` = 1 at a falling edge clears both read outputs to zero.
- R8: The write enable vector has at most one bit set, and no bit set when `wr_en` is 0. Each read select vector has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes occur on the rising edge and read capture on the falling edge |
| rst | input | 1 | Synchronous active-high reset for the words and the read outputs |
| wr_en | input | 1 | Write enable that gates the write decoder |
| wr_sel | input | 5 | Index of the word to write |
| wr_data | input | 32 | Value to write |
| rd_a_sel | input | 5 | Index read by port A |
| rd_b_sel | input | 5 | Index read by port B |
| rd_a_data | output | 32 | Port A result, registered on the falling edge |
| rd_b_data | output | 32 | Port B result, registered on the falling edge |

## Verification
The bench reads back the word written in the same cycle. A design that captured reads on the rising edge would return the stale value here. It reads the same index on both ports, which would expose a cross-wired or shared select. It drives writes with the enable low and writes while reset is high; a decoder that ignored either gate would corrupt a word that a later full sweep reads back. The bench also targets indices 0 and 31 and checks that the outputs hold across rising edges. These checks catch decoder off-by-one errors and an output register clocked on the wrong edge.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  parameter int RF_ENTRIES_DEF = 32;
  parameter int RF_WIDTH_DEF   = 32;

  function automatic int sel_bits(input int entries);
    return (entries < 2) ? 1 : $clog2(entries);
  endfunction
endpackage

// File: rtl/rf_onehot_dec.sv
`timescale 1ns/1ps
module rf_onehot_dec #(
  parameter int ENTRIES = 32,
  parameter int SEL_W   = 5
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  output logic [ENTRIES-1:0] hot
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_line
    assign hot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ENTRIES-1:0]             wr_hot,
  input  logic [WIDTH-1:0]               wr_data,
  output logic [ENTRIES-1:0][WIDTH-1:0]  words
);
  // write value broadcast to every word; the one-hot line picks the taker
  for (genvar i = 0; i < ENTRIES; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
      end else if (wr_hot[i]) begin
        words[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  parameter int SEL_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_W-1:0]              sel,
  input  logic [ENTRIES-1:0][WIDTH-1:0] words,
  output logic [ENTRIES-1:0]            hot,
  output logic [WIDTH-1:0]              data_q
);
  logic [ENTRIES-1:0][WIDTH-1:0] masked;
  logic [WIDTH-1:0]              bus;

  rf_onehot_dec #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_dec (
    .en  (1'b1),
    .sel (sel),
    .hot (hot)
  );

  // each word gated by its select line, then merged onto the port bus
  for (genvar i = 0; i < ENTRIES; i++) begin : g_gate
    assign masked[i] = words[i] & {WIDTH{hot[i]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      bus = bus | masked[i];
    end
  end

  // capture on the falling edge so a rising-edge write is already visible
  always_ff @(negedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else begin
      data_q <= bus;
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
`timescale 1ns/1ps
module regfile_2r1w
  import rf_pkg::*;
#(
  parameter int ENTRIES = RF_ENTRIES_DEF,
  parameter int WIDTH   = RF_WIDTH_DEF,
  localparam int SEL_W  = sel_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data
);
  logic [ENTRIES-1:0]            wr_hot;
  logic [ENTRIES-1:0]            rd_hot_a;
  logic [ENTRIES-1:0]            rd_hot_b;
  logic [ENTRIES-1:0][WIDTH-1:0] words;

  rf_onehot_dec #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_wr_dec (
    .en  (wr_en),
    .sel (wr_sel),
    .hot (wr_hot)
  );

  rf_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_hot  (wr_hot),
    .wr_data (wr_data),
    .words   (words)
  );

  rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_port_a (
    .clk    (clk),
    .rst    (rst),
    .sel    (rd_a_sel),
    .words  (words),
    .hot    (rd_hot_a),
    .data_q (rd_a_data)
  );

  rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_port_b (
    .clk    (clk),
    .rst    (rst),
    .sel    (rd_b_sel),
    .words  (words),
    .hot    (rd_hot_b),
    .data_q (rd_b_data)
  );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  parameter int SEL_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [WIDTH-1:0]   wr_data,
  input logic [SEL_W-1:0]   rd_a_sel,
  input logic [SEL_W-1:0]   rd_b_sel,
  input logic [WIDTH-1:0]   rd_a_data,
  input logic [WIDTH-1:0]   rd_b_data,
  input logic [ENTRIES-1:0] wr_hot,
  input logic [ENTRIES-1:0] rd_hot_a,
  input logic [ENTRIES-1:0] rd_hot_b
);
  p_wr_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hot));

  p_wr_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_hot == '0));

  p_rd_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot(rd_hot_a) && $onehot(rd_hot_b));

  p_same_sel_r4: assert property (@(negedge clk) disable iff (rst)
    (rd_a_sel == rd_b_sel) |=> (rd_a_data == rd_b_data));

  p_fwd_r6: assert property (@(negedge clk) disable iff (rst)
    (wr_en && (rd_a_sel == wr_sel)) |=> (rd_a_data == $past(wr_data)));
endmodule

bind regfile_2r1w rf_checker #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_a_sel  (rd_a_sel),
  .rd_b_sel  (rd_b_sel),
  .rd_a_data (rd_a_data),
  .rd_b_data (rd_b_data),
  .wr_hot    (wr_hot),
  .rd_hot_a  (rd_hot_a),
  .rd_hot_b  (rd_hot_b)
);

// File: tb/tb_regfile_2r1w.sv
`timescale 1ns/1ps
module tb_regfile_2r1w;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_sel = '0;
  logic [4:0]  rd_b_sel = '0;
  logic [31:0] rd_a_data;
  logic [31:0] rd_b_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] mdl [32];

  always #2 clk = ~clk;

  regfile_2r1w dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  ws;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
  } vec_t;

  // stimulus table: write, then same-cycle and cross-port reads
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd0,  32'hDEADBEEF, 5'd0,  5'd31},
    '{1'b1, 5'd31, 32'hFFFFFFFF, 5'd31, 5'd0 },
    '{1'b1, 5'd7,  32'h00000001, 5'd7,  5'd7 },
    '{1'b0, 5'd7,  32'h12345678, 5'd7,  5'd0 },
    '{1'b1, 5'd16, 32'h80000000, 5'd15, 5'd16},
    '{1'b1, 5'd15, 32'h0F0F0F0F, 5'd16, 5'd15},
    '{1'b0, 5'd0,  32'h00000000, 5'd0,  5'd31},
    '{1'b1, 5'd7,  32'hA5A5A5A5, 5'd31, 5'd7 },
    '{1'b1, 5'd1,  32'h5A5A5A5A, 5'd1,  5'd1 },
    '{1'b0, 5'd31, 32'hCAFEF00D, 5'd31, 5'd31}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // caller is 0.5 ns past a falling edge; one full cycle is applied
  task automatic cyc(input logic r, input logic we, input logic [4:0] ws,
                     input logic [31:0] wd, input logic [4:0] ra,
                     input logic [4:0] rb, input string tag);
    logic [31:0] hold_a, hold_b;
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd;
    rd_a_sel = ra; rd_b_sel = rb;
    hold_a = rd_a_data; hold_b = rd_b_data;
    @(posedge clk); #0.5;
    chk("R5 port A held across rising edge", rd_a_data, hold_a);
    chk("R5 port B held across rising edge", rd_b_data, hold_b);
    if (r) begin
      for (int i = 0; i < 32; i++) mdl[i] = '0;
    end else if (we) begin
      mdl[ws] = wd;
    end
    @(negedge clk); #0.5;
    chk(tag, rd_a_data, r ? 32'h0 : mdl[ra]);
    chk(tag, rd_b_data, r ? 32'h0 : mdl[rb]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      cyc(1'b0, 1'b0, 5'(i), 32'hBAD0BAD0, 5'(i), 5'(31 - i), tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    #0.5;
    chk("R7 port A zero in reset", rd_a_data, 32'h0);
    chk("R7 port B zero in reset", rd_b_data, 32'h0);
    cyc(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R7 reset cycle");

    // R1 R6: fill every word, reading it back in the same cycle
    for (int i = 0; i < 32; i++) begin
      cyc(1'b0, 1'b1, 5'(i), 32'h1000_0000 + 32'(i * 32'h01010101),
          5'(i), 5'((i + 31) % 32), "R6 same-cycle read / R1 fill");
    end
    sweep("R1 sweep after fill");

    // R3 table walk
    for (int v = 0; v < NV; v++) begin
      cyc(1'b0, VECS[v].we, VECS[v].ws, VECS[v].wd, VECS[v].ra, VECS[v].rb,
          "R3 table vector");
    end

    // R2: disabled writes with a changing target, read the target back
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, 5'(i * 4 + 3), 32'hFEEDFACE ^ 32'(i),
          5'(i * 4 + 3), 5'(i * 4 + 3), "R2 write enable low");
    end
    sweep("R2 sweep after disabled writes");

    // R4: same index on both ports, checked for equality
    for (int i = 0; i < 32; i += 5) begin
      cyc(1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(i), "R4 same index");
      chk("R4 ports equal", rd_a_data, rd_b_data);
    end

    // R3 random traffic against the model
    for (int i = 0; i < 300; i++) begin
      cyc(1'b0, 1'($urandom), 5'($urandom), $urandom, 5'($urandom),
          5'($urandom), "R3 random traffic");
    end

    // R7: reset with a write pending clears all words
    cyc(1'b1, 1'b1, 5'd9, 32'h99999999, 5'd9, 5'd0, "R7 reset with write");
    cyc(1'b1, 1'b1, 5'd31, 32'h31313131, 5'd31, 5'd9, "R7 reset with write");
    sweep("R7 sweep after reset");
    cyc(1'b0, 1'b1, 5'd31, 32'h0BADCAFE, 5'd31, 5'd31, "R6 write after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule